// File: doc/BRIEF.md
# Interrupt PSW Swap Controller

This block performs the context switch of a small processor whose entire architectural state is held in one 64-bit status word. When an interrupt is accepted, the controller stores the running status word into a fixed save slot in memory for that interrupt class, with the interruption code placed into the word. It then fetches that class's fixed handler status word from memory and makes it current. There is no stack and no vector table. Each of the five classes owns one save slot and one handler slot at fixed doubleword addresses.

The same engine serves a "load status word" operation: the operating system returns from a handler by reloading a saved word from any doubleword address. A privileged operation that is requested while the current word says problem (user) state is refused. It becomes a program-class interrupt with code 2, and the refused operation has no effect. Memory is reached through a 64-bit request/acknowledge port that carries one transfer per acknowledge.

The status word uses big-endian bit numbering: architectural bit k sits at port index 63-k. The fields are system mask on [63:56], protection key on [55:52], character-set bit on [51], machine-check enable on [50], wait bit on [49], problem-state bit on [48], interruption code on [47:32], length code on [31:30], condition code on [29:28], program mask on [27:24] and instruction address on [23:0]. Class numbers are 0 external, 1 supervisor call, 2 program, 3 machine check and 4 I/O.

Top module: `psw_swap_ctrl`

## Requirements
- R1: After reset, `psw` is all zeros, `busy`, `mem_req`, `irq_take` and `priv_ok` are 0.
- R2: On accepting class c, the first memory request is a write to byte address 0x18+8*c. The written word is the current `psw` with [47:32] replaced by the class code: the 16-bit field c of `irq_code` (bits 16c+15..16c), except for class 1, which stores only the low 8 bits of its field zero-extended, and a privilege fault, which stores 2.
- R3: After the write is acknowledged, the controller reads byte address 0x58+8*c and loads the returned word into `psw` on the acknowledge edge. `busy` is high from the cycle after acceptance until that load, and `psw` changes at no other time.
- R4: Among enabled pending classes, the fixed priority is machine check (3), program (2), supervisor call (1), external (0), I/O (4).
- R5: Supervisor call and program requests are always enabled. External needs `psw[56]`. Machine check needs `psw[50]`. I/O needs `io_chan` in 0..6 and `psw[63-io_chan]`. I/O on channel 7 is never taken.
- R6: In supervisor state (`psw[48]`=0), with no enabled interrupt, `lpsw_req` reads the doubleword at `lpsw_addr` and loads it into `psw`. No write is made.
- R7: In problem state (`psw[48]`=1), `lpsw_req` or `priv_req` raises a program interrupt with code 2. The requested load does not happen and `priv_ok` stays 0.
- R8: In supervisor state, with no enabled interrupt, `priv_req` pulses `priv_ok` for one cycle, one cycle later. `psw` is unchanged.
- R9: Once raised, `mem_req` holds with stable address, direction and data until `mem_ack`. Each interrupt makes exactly one write and then one read.
- R10: `irq_take` is a one-hot pulse naming the accepted class. It appears in the first cycle of the write request.
- R11: An enabled interrupt wins over an operation requested in the same cycle, and that operation is dropped. Requests of any kind that arrive while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 5 | Pending request per class, index = class number |
| irq_code | input | 80 | Interruption code per class, 16 bits each, class c at [16c+15:16c] |
| io_chan | input | 3 | Channel of the pending I/O request |
| lpsw_req | input | 1 | Load-status-word request |
| lpsw_addr | input | 24 | Byte address of the word to load |
| priv_req | input | 1 | Other privileged operation request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the doubleword |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Transfer done this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` on a read |
| psw | output | 64 | Current status word |
| busy | output | 1 | Swap or load in progress |
| irq_take | output | 5 | One-hot pulse for the accepted class |
| priv_ok | output | 1 | Privileged operation allowed (one-cycle pulse) |

## Verification
Directed request patterns walk down the priority ladder by removing the winner each time. This separates a wrong ordering from a wrong slot address, since each handler slot holds a distinct word. Cases with every class masked, and with I/O on channel 7, separate gating faults from arbitration faults. Supervisor-call codes with non-zero upper bytes show whether the code is truncated. A status word in problem state, loaded through the load operation, shows whether the privilege check and code 2 replace the requested operation. The random phase draws handler words, masks, request sets and codes from a fixed seed, so that mask bits taken from a freshly loaded word decide the next arbitration.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;

  localparam int NCLS   = 5;
  localparam int CODE_W = 16;
  localparam int PSW_W  = 64;

  localparam int CLS_EXT = 0;
  localparam int CLS_SVC = 1;
  localparam int CLS_PRG = 2;
  localparam int CLS_MCK = 3;
  localparam int CLS_IO  = 4;

  localparam logic [CODE_W-1:0] PRIV_FAULT_CODE = 16'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WR_OLD = 2'd1,
    ST_RD_NEW = 2'd2
  } swap_st_e;

  // class served at a given priority rank: 3,2,1,0 then 4
  function automatic int unsigned cls_at_rank(input int unsigned rank);
    if (rank < 4) return 3 - rank;
    return rank;
  endfunction

endpackage

// File: rtl/psw_irq_gate.sv
module psw_irq_gate
  import psw_swap_pkg::*;
(
  input  logic [PSW_W-1:0] psw,
  input  logic [NCLS-1:0]  irq_req,
  input  logic [2:0]       io_chan,
  input  logic             priv_fault,
  output logic [NCLS-1:0]  irq_en
);

  logic [7:0] sys_mask;
  logic       chan_on;

  assign sys_mask = psw[63:56];
  // architectural mask bit k lives at sys_mask[7-k]
  assign chan_on  = (io_chan != 3'd7) && sys_mask[3'd7 - io_chan];

  always_comb begin
    irq_en          = '0;
    irq_en[CLS_EXT] = irq_req[CLS_EXT] && sys_mask[0];
    irq_en[CLS_SVC] = irq_req[CLS_SVC];
    irq_en[CLS_PRG] = irq_req[CLS_PRG] || priv_fault;
    irq_en[CLS_MCK] = irq_req[CLS_MCK] && psw[50];
    irq_en[CLS_IO]  = irq_req[CLS_IO] && chan_on;
  end

endmodule

// File: rtl/psw_irq_arbiter.sv
module psw_irq_arbiter
  import psw_swap_pkg::*;
#(
  parameter int N     = NCLS,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          any
);

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int r = 0; r < N; r++) begin
      if (!any && req[cls_at_rank(r)]) begin
        grant[cls_at_rank(r)] = 1'b1;
        grant_idx             = IW'(cls_at_rank(r));
        any                   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/psw_swap_seq.sv
module psw_swap_seq
  import psw_swap_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_irq,
  input  logic             start_load,
  input  logic [AW-1:0]    save_addr,
  input  logic [AW-1:0]    fetch_addr,
  input  logic [AW-1:0]    load_addr,
  input  logic [PSW_W-1:0] save_word,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [PSW_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PSW_W-1:0] mem_rdata,
  output logic             load_en,
  output logic [PSW_W-1:0] load_word,
  output logic             busy
);

  swap_st_e      st;
  logic [AW-1:0] fetch_q;

  assign busy      = (st != ST_IDLE);
  assign load_en   = (st == ST_RD_NEW) && mem_ack;
  assign load_word = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fetch_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_irq) begin
            st        <= ST_WR_OLD;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= save_addr;
            mem_wdata <= save_word;
            fetch_q   <= fetch_addr;
          end else if (start_load) begin
            st       <= ST_RD_NEW;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= load_addr;
          end
        end
        ST_WR_OLD: begin
          if (mem_ack) begin
            st       <= ST_RD_NEW;
            mem_we   <= 1'b0;
            mem_addr <= fetch_q;
          end
        end
        ST_RD_NEW: begin
          if (mem_ack) begin
            st      <= ST_IDLE;
            mem_req <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
  import psw_swap_pkg::*;
#(
  parameter int                AW        = 24,
  parameter logic [AW-1:0]     OLD_BASE  = 24'h000018,
  parameter logic [AW-1:0]     NEW_BASE  = 24'h000058,
  parameter logic [PSW_W-1:0]  RESET_PSW = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCLS-1:0]        irq_req,
  input  logic [NCLS*CODE_W-1:0] irq_code,
  input  logic [2:0]             io_chan,
  input  logic                   lpsw_req,
  input  logic [AW-1:0]          lpsw_addr,
  input  logic                   priv_req,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [PSW_W-1:0]       mem_wdata,
  input  logic                   mem_ack,
  input  logic [PSW_W-1:0]       mem_rdata,
  output logic [PSW_W-1:0]       psw,
  output logic                   busy,
  output logic [NCLS-1:0]        irq_take,
  output logic                   priv_ok
);

  localparam int IW = $clog2(NCLS);

  logic              problem, idle, fault;
  logic [NCLS-1:0]   irq_en, grant;
  logic [IW-1:0]     gidx;
  logic              any_irq, take, load_go, priv_go;
  logic [CODE_W-1:0] cls_code [NCLS];
  logic [CODE_W-1:0] code_sel;
  logic [PSW_W-1:0]  save_word;
  logic [AW-1:0]     slot_off, save_addr, fetch_addr;
  logic              load_en;
  logic [PSW_W-1:0]  load_word;

  assign problem = psw[48];
  assign idle    = !busy;
  assign fault   = idle && problem && (lpsw_req || priv_req);

  for (genvar g = 0; g < NCLS; g++) begin : g_code
    if (g == CLS_SVC) begin : g_svc
      assign cls_code[g] = {{(CODE_W-8){1'b0}}, irq_code[g*CODE_W +: 8]};
    end else begin : g_full
      assign cls_code[g] = irq_code[g*CODE_W +: CODE_W];
    end
  end

  psw_irq_gate u_gate (
    .psw        (psw),
    .irq_req    (irq_req),
    .io_chan    (io_chan),
    .priv_fault (fault),
    .irq_en     (irq_en)
  );

  psw_irq_arbiter #(.N(NCLS)) u_arb (
    .req       (irq_en),
    .grant     (grant),
    .grant_idx (gidx),
    .any       (any_irq)
  );

  assign take     = idle && any_irq;
  assign load_go  = idle && !any_irq && lpsw_req && !problem;
  assign priv_go  = idle && !any_irq && priv_req && !problem;

  assign code_sel = (fault && gidx == IW'(CLS_PRG)) ? PRIV_FAULT_CODE : cls_code[gidx];
  assign save_word = {psw[63:48], code_sel, psw[31:0]};

  assign slot_off   = {{(AW-IW){1'b0}}, gidx} << 3;
  assign save_addr  = OLD_BASE + slot_off;
  assign fetch_addr = NEW_BASE + slot_off;

  psw_swap_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_irq  (take),
    .start_load (load_go),
    .save_addr  (save_addr),
    .fetch_addr (fetch_addr),
    .load_addr  (lpsw_addr),
    .save_word  (save_word),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .load_en    (load_en),
    .load_word  (load_word),
    .busy       (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psw      <= RESET_PSW;
      irq_take <= '0;
      priv_ok  <= 1'b0;
    end else begin
      if (load_en) psw <= load_word;
      irq_take <= take ? grant : '0;
      priv_ok  <= priv_go;
    end
  end

endmodule

// File: rtl/psw_swap_ctrl_chk.sv
module psw_swap_ctrl_chk #(
  parameter int            AW       = 24,
  parameter logic [AW-1:0] OLD_BASE = 24'h000018
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [63:0]   mem_wdata,
  input logic          mem_ack,
  input logic [63:0]   psw,
  input logic          busy,
  input logic [4:0]    irq_take,
  input logic          priv_ok
);

  // R3: memory traffic only while busy
  p_req_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R3: status word only changes on an acknowledged read
  p_psw_load_only_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && !mem_we && mem_ack) |=> $stable(psw));

  // R9: request held stable until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2: writes go to a save slot only
  p_write_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr >= OLD_BASE && mem_addr <= OLD_BASE + AW'(32) && mem_addr[2:0] == 3'b000));

  // R10: one-hot take, coinciding with the save write
  p_take_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_take));

  p_take_write_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_take != 5'd0) |-> (mem_req && mem_we && busy));

  // R11: nothing is accepted while busy
  p_busy_no_take_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> (irq_take == 5'd0 && !priv_ok));

  // R8: grant only in supervisor state and only when idle
  p_priv_sup_r8: assert property (@(posedge clk) disable iff (rst)
    priv_ok |-> (!psw[48] && !busy));

endmodule

bind psw_swap_ctrl psw_swap_ctrl_chk #(.AW(AW), .OLD_BASE(OLD_BASE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .psw       (psw),
  .busy      (busy),
  .irq_take  (irq_take),
  .priv_ok   (priv_ok)
);

// File: tb/psw_swap_ctrl_bench.sv
`timescale 1ns/1ps
module psw_swap_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  irq_req = '0;
  logic [79:0] irq_code = '0;
  logic [2:0]  io_chan = '0;
  logic        lpsw_req = 1'b0;
  logic [23:0] lpsw_addr = '0;
  logic        priv_req = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata, psw;
  logic        busy, priv_ok;
  logic [4:0]  irq_take;

  always #2.5 clk = ~clk;

  psw_swap_ctrl u_psw_swap_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_code(irq_code), .io_chan(io_chan),
    .lpsw_req(lpsw_req), .lpsw_addr(lpsw_addr), .priv_req(priv_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .psw(psw), .busy(busy),
    .irq_take(irq_take), .priv_ok(priv_ok)
  );

  // memory model: acknowledge one cycle after a request, 64 doublewords
  logic [63:0] mem [0:63];
  logic        bk_we = 1'b0;
  logic [5:0]  bk_idx = '0;
  logic [63:0] bk_val = '0;
  int          wr_cnt, rd_cnt;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wr_cnt    <= 0;
      rd_cnt    <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[8:3]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_cnt <= rd_cnt + 1;
        end
        mem_rdata <= mem[mem_addr[8:3]];
      end
    end
    if (bk_we) mem[bk_idx] <= bk_val;
  end

  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;
  logic [63:0] exp_psw;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [4:0] rq, input logic [63:0] p,
                              input logic [2:0] ch, input bit flt);
    if (rq[3] && p[50]) return 3;
    if (rq[2] || flt) return 2;
    if (rq[1]) return 1;
    if (rq[0] && p[56]) return 0;
    if (rq[4] && ch != 3'd7 && p[63 - int'(ch)]) return 4;
    return -1;
  endfunction

  function automatic logic [15:0] code_of(input int cls, input logic [79:0] codes, input bit flt);
    logic [15:0] c;
    c = codes[cls*16 +: 16];
    if (cls == 2 && flt) return 16'd2;
    if (cls == 1) return {8'h00, c[7:0]};
    return c;
  endfunction

  task automatic preload(input int idx, input logic [63:0] val);
    @(negedge clk);
    bk_we = 1'b1; bk_idx = 6'(idx); bk_val = val;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic run_case(input string tag, input logic [4:0] rq, input logic [79:0] codes,
                          input logic [2:0] ch, input bit lp, input bit pv, input logic [23:0] la);
    bit flt;
    int cls, w0, r0;
    logic [63:0] newv, loadv, oldexp;
    flt = exp_psw[48] && (lp || pv);
    cls = pick(rq, exp_psw, ch, flt);
    w0 = wr_cnt; r0 = rd_cnt;
    loadv = mem[la[8:3]];
    if (cls >= 0) begin
      newv   = mem[(24'h58 + 24'(cls*8)) >> 3];
      oldexp = {exp_psw[63:48], code_of(cls, codes, flt), exp_psw[31:0]};
    end else begin
      newv = '0; oldexp = '0;
    end
    @(negedge clk);
    irq_req = rq; irq_code = codes; io_chan = ch; lpsw_req = lp; lpsw_addr = la; priv_req = pv;
    @(negedge clk);
    irq_req = '0; lpsw_req = 1'b0; priv_req = 1'b0;
    if (cls >= 0) begin
      chk({tag, " R10 take"}, 64'(irq_take), 64'(5'b1 << cls));
      chk({tag, " R3 busy"}, 64'(busy), 64'd1);
      chk({tag, " R2 save addr"}, 64'(mem_addr), 64'(24'h18 + 24'(cls*8)));
      chk({tag, " R7 no grant"}, 64'(priv_ok), 64'd0);
      wait_idle();
      chk({tag, " R3 loaded"}, psw, newv);
      chk({tag, " R2 saved word"}, mem[(24'h18 + 24'(cls*8)) >> 3], oldexp);
      chk({tag, " R9 transfers"}, 64'((wr_cnt - w0) * 16 + (rd_cnt - r0)), 64'h11);
      exp_psw = newv;
    end else if (lp) begin
      chk({tag, " R6 busy"}, 64'(busy), 64'd1);
      wait_idle();
      chk({tag, " R6 loaded"}, psw, loadv);
      chk({tag, " R6 no write"}, 64'((wr_cnt - w0) * 16 + (rd_cnt - r0)), 64'h01);
      exp_psw = loadv;
    end else if (pv) begin
      chk({tag, " R8 grant"}, 64'(priv_ok), 64'd1);
      chk({tag, " R8 psw"}, psw, exp_psw);
      @(negedge clk);
      chk({tag, " R8 pulse"}, 64'(priv_ok), 64'd0);
    end else begin
      repeat (4) @(negedge clk);
      chk({tag, " R5 idle"}, 64'(busy) * 2 + 64'(wr_cnt - w0), 64'd0);
      chk({tag, " R5 psw"}, psw, exp_psw);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  localparam logic [63:0] SUP_ALL = 64'hFF04_0000_0012_3400;
  localparam logic [63:0] PROB    = 64'hFF05_0000_0000_0777;

  initial begin
    int seed, w0, r0;
    bit saw;
    logic [63:0] v;
    seed = int'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) preload(i, {$urandom, $urandom});
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 psw", psw, 64'd0);
    chk("R1 outs", {59'd0, busy, mem_req, priv_ok, irq_take != 5'd0, 1'b0}, 64'd0);
    exp_psw = '0;

    // handler words: supervisor state, all masks on, distinct addresses
    for (int c = 0; c < 5; c++) preload(11 + c, SUP_ALL | 64'(c + 1));
    preload(32, SUP_ALL);
    preload(33, PROB);

    run_case("masked", 5'b11001, {5{16'h1111}}, 3'd2, 1'b0, 1'b0, 24'h0);
    run_case("R2 svc code", 5'b00010, {16'h0, 16'h0, 16'h0, 16'hABCD, 16'h0}, 3'd0, 1'b0, 1'b0, 24'h0);
    run_case("R6 load", 5'b00000, '0, 3'd0, 1'b1, 1'b0, 24'h100);
    run_case("R4 all", 5'b11111, {16'h4444, 16'h3333, 16'h2222, 16'h1111, 16'h0E0E}, 3'd1, 1'b0, 1'b0, 24'h0);
    run_case("R4 no mck", 5'b10111, {16'h4444, 16'h3333, 16'h2222, 16'h1111, 16'h0E0E}, 3'd1, 1'b0, 1'b0, 24'h0);
    run_case("R4 svc", 5'b10011, {16'h4444, 16'h3333, 16'h2222, 16'h1199, 16'h0E0E}, 3'd1, 1'b0, 1'b0, 24'h0);
    run_case("R4 ext", 5'b10001, {16'h4444, 16'h3333, 16'h2222, 16'h1111, 16'h0E0E}, 3'd1, 1'b0, 1'b0, 24'h0);
    run_case("R5 io", 5'b10000, {16'h4444, 64'h0}, 3'd2, 1'b0, 1'b0, 24'h0);
    run_case("R5 chan7", 5'b10000, {16'h4444, 64'h0}, 3'd7, 1'b0, 1'b0, 24'h0);
    run_case("R8 priv", 5'b00000, '0, 3'd0, 1'b0, 1'b1, 24'h0);
    run_case("R11 ext wins", 5'b00001, {64'h0, 16'h0D0D}, 3'd0, 1'b1, 1'b0, 24'h108);
    run_case("R6 to problem", 5'b00000, '0, 3'd0, 1'b1, 1'b0, 24'h108);
    run_case("R7 priv fault", 5'b00000, '0, 3'd0, 1'b0, 1'b1, 24'h0);
    run_case("R6 to problem2", 5'b00000, '0, 3'd0, 1'b1, 1'b0, 24'h108);
    run_case("R7 load fault", 5'b00000, '0, 3'd0, 1'b1, 1'b0, 24'h100);

    // R11: requests during a swap are ignored
    w0 = wr_cnt; r0 = rd_cnt; saw = 1'b0;
    v = mem[(24'h58) >> 3];
    @(negedge clk);
    irq_req = 5'b00001; irq_code = 80'h5;
    @(negedge clk);
    irq_req = '0; lpsw_req = 1'b1; lpsw_addr = 24'h108; priv_req = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      saw |= priv_ok;
    end
    lpsw_req = 1'b0; priv_req = 1'b0;
    for (int i = 0; i < 50 && busy; i++) begin
      @(negedge clk);
      saw |= priv_ok;
    end
    chk("R11 busy load ignored", psw, v);
    chk("R11 busy transfers", 64'((wr_cnt - w0) * 16 + (rd_cnt - r0)), 64'h11);
    chk("R11 busy no grant", 64'(saw), 64'd0);
    exp_psw = v;

    // constrained random phase
    for (int it = 0; it < 60; it++) begin
      logic [4:0]  rq;
      logic [79:0] cd;
      logic [2:0]  ch;
      bit          lp, pv;
      for (int c = 0; c < 5; c++) preload(11 + c, {$urandom, $urandom});
      rq = 5'($urandom % 32);
      if ($urandom % 3 == 0) rq = '0;
      cd = {16'($urandom), $urandom, $urandom};
      ch = 3'($urandom % 8);
      lp = ($urandom % 4 == 0);
      pv = !lp && ($urandom % 4 == 0);
      run_case("rand", rq, cd, ch, lp, pv, {15'd0, 6'($urandom % 64), 3'd0});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule